// File: doc/BRIEF.md
# Dual-Bank Wide Vector Register File

This block stores the wide operands used by custom extension instructions in a coprocessor datapath. It holds thirty-two 128-bit registers, split evenly into bank A and bank B. Every instruction can read up to three registers at once. Read data is combinational and is the value held before the clock edge. The instruction can also deliver up to two 128-bit results. These results are committed at the next rising clock edge.

The two write ports are steered by bank. When both results are requested, they must land in different banks. If both targets fall in the same bank, the block drops both writes and raises an error flag for one cycle. A read port or write port whose enable is low has no effect, and an idle read port returns zero. The same register may be read and written by one instruction. The read sees the old contents and the new value appears after the edge.

Top module: `wide_regfile`

## Requirements
- R1: A register address is 5 bits. Bit 4 picks the bank (0 = bank A, 1 = bank B) and bits 3:0 pick one of 16 entries, so an address with bit 4 clear always lands in bank A.
- R2: Three read ports each return the 128-bit contents of the addressed register combinationally, independently of one another.
- R3: A read port whose enable is low drives all-zero data.
- R4: When both write ports are enabled and their addresses differ in bit 4, both writes commit on the same rising edge.
- R5: A read of a register being written in the same cycle returns the pre-write value; the written value is visible from the following cycle on.
- R6: When both write ports are enabled and their addresses agree in bit 4, neither write happens and `bankConflict` is high for exactly the cycle following that edge; otherwise `bankConflict` is low.
- R7: A single enabled write port commits to either bank without raising `bankConflict`.
- R8: With `rst` high at a rising edge, all 32 registers and `bankConflict` become zero.
- R9: A write port whose enable is low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rdEn0 | input | 1 | Read port 0 enable |
| rdAddr0 | input | 5 | Read port 0 address |
| rdData0 | output | 128 | Read port 0 data |
| rdEn1 | input | 1 | Read port 1 enable |
| rdAddr1 | input | 5 | Read port 1 address |
| rdData1 | output | 128 | Read port 1 data |
| rdEn2 | input | 1 | Read port 2 enable |
| rdAddr2 | input | 5 | Read port 2 address |
| rdData2 | output | 128 | Read port 2 data |
| wrEn0 | input | 1 | Write port 0 enable |
| wrAddr0 | input | 5 | Write port 0 address |
| wrData0 | input | 128 | Write port 0 data |
| wrEn1 | input | 1 | Write port 1 enable |
| wrAddr1 | input | 5 | Write port 1 address |
| wrData1 | input | 128 | Write port 1 data |
| bankConflict | output | 1 | One-cycle flag for a dropped same-bank write pair |

## Verification
Two things can happen in the same cycle: a register is read while the same register is being written, and the pair of writes is checked against the bank rule. The bench drives vectors in which read port 0, and read port 1, address a register that one of the write ports targets. Some of these writes are legal and some collide. Each read is sampled before the edge and must show the old contents. It is sampled again after the edge and must show either the new value or, when the pair collided, the untouched value. The error flag is compared at the same moment against a reference model kept in the bench.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int DEF_DATA_W  = 128;
  localparam int DEF_ENTRIES = 16;
  localparam int NUM_BANKS   = 2;
  localparam int NUM_RD      = 3;

  typedef struct packed {
    logic commit0;
    logic commit1;
    logic collide;
  } wrf_strobe_t;
endpackage

// File: rtl/wrf_ctrl.sv
module wrf_ctrl
  import wrf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn0,
  input  logic        wrEn1,
  input  logic        bank0,
  input  logic        bank1,
  output wrf_strobe_t strobes,
  output logic        conflictFlag
);
  always_comb begin
    strobes.collide = wrEn0 && wrEn1 && (bank0 == bank1);
    strobes.commit0 = wrEn0 && !strobes.collide;
    strobes.commit1 = wrEn1 && !strobes.collide;
  end

  always_ff @(posedge clk) begin
    if (rst) conflictFlag <= 1'b0;
    else     conflictFlag <= strobes.collide;
  end

  // R6: the flag only ever follows a same-bank pair of enabled writes
  assert_flag_cause_R6: assert property (@(posedge clk) disable iff (rst)
    conflictFlag |-> $past(wrEn0 && wrEn1 && (bank0 == bank1)));

  // R7: a lone write never flags
  assert_lone_write_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (wrEn0 != wrEn1) |=> !conflictFlag);
endmodule

// File: rtl/wrf_datapath.sv
module wrf_datapath
  import wrf_pkg::*;
#(
  parameter int DATA_W  = DEF_DATA_W,
  parameter int ENTRIES = DEF_ENTRIES,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  wrf_strobe_t       strobes,
  input  logic [ADDR_W-1:0] wrAddr0,
  input  logic [DATA_W-1:0] wrData0,
  input  logic [ADDR_W-1:0] wrAddr1,
  input  logic [DATA_W-1:0] wrData1,
  input  logic              rdEn   [NUM_RD],
  input  logic [ADDR_W-1:0] rdAddr [NUM_RD],
  output logic [DATA_W-1:0] rdData [NUM_RD]
);
  logic [DATA_W-1:0] bankMem [NUM_BANKS][ENTRIES];

  logic             bank0, bank1;
  logic [IDX_W-1:0] idx0, idx1;
  assign bank0 = wrAddr0[ADDR_W-1];
  assign bank1 = wrAddr1[ADDR_W-1];
  assign idx0  = wrAddr0[IDX_W-1:0];
  assign idx1  = wrAddr1[IDX_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit0, hit1;
    assign hit0 = strobes.commit0 && (int'(bank0) == b);
    assign hit1 = strobes.commit1 && (int'(bank1) == b);

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int e = 0; e < ENTRIES; e++) bankMem[b][e] <= '0;
      end else if (hit0) begin
        bankMem[b][idx0] <= wrData0;
      end else if (hit1) begin
        bankMem[b][idx1] <= wrData1;
      end
    end

    // R9: a bank no write port reaches keeps its first entry unchanged
    assert_bank_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
      (!hit0 && !hit1) |=> (bankMem[b][0] == $past(bankMem[b][0])));

    // R8: reset leaves first and last entries of every bank cleared
    assert_reset_clears_R8: assert property (@(posedge clk)
      $past(rst) |-> (bankMem[b][0] == '0 && bankMem[b][ENTRIES-1] == '0));
  end

  // R6: control never hands one bank two writers
  assert_single_writer_R6: assert property (@(posedge clk) disable iff (rst)
    !(strobes.commit0 && strobes.commit1 && (bank0 == bank1)));

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    always_comb begin
      if (rdEn[p]) rdData[p] = bankMem[rdAddr[p][ADDR_W-1]][rdAddr[p][IDX_W-1:0]];
      else         rdData[p] = '0;
    end
  end
endmodule

// File: rtl/wide_regfile.sv
module wide_regfile
  import wrf_pkg::*;
#(
  parameter int DATA_W  = DEF_DATA_W,
  parameter int ENTRIES = DEF_ENTRIES,
  localparam int ADDR_W = $clog2(ENTRIES) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdEn0,
  input  logic [ADDR_W-1:0] rdAddr0,
  output logic [DATA_W-1:0] rdData0,
  input  logic              rdEn1,
  input  logic [ADDR_W-1:0] rdAddr1,
  output logic [DATA_W-1:0] rdData1,
  input  logic              rdEn2,
  input  logic [ADDR_W-1:0] rdAddr2,
  output logic [DATA_W-1:0] rdData2,
  input  logic              wrEn0,
  input  logic [ADDR_W-1:0] wrAddr0,
  input  logic [DATA_W-1:0] wrData0,
  input  logic              wrEn1,
  input  logic [ADDR_W-1:0] wrAddr1,
  input  logic [DATA_W-1:0] wrData1,
  output logic              bankConflict
);
  wrf_strobe_t       strobes;
  logic              rdEnV   [NUM_RD];
  logic [ADDR_W-1:0] rdAddrV [NUM_RD];
  logic [DATA_W-1:0] rdDataV [NUM_RD];

  assign rdEnV[0] = rdEn0;  assign rdAddrV[0] = rdAddr0;
  assign rdEnV[1] = rdEn1;  assign rdAddrV[1] = rdAddr1;
  assign rdEnV[2] = rdEn2;  assign rdAddrV[2] = rdAddr2;
  assign rdData0 = rdDataV[0];
  assign rdData1 = rdDataV[1];
  assign rdData2 = rdDataV[2];

  wrf_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .wrEn0(wrEn0), .wrEn1(wrEn1),
    .bank0(wrAddr0[ADDR_W-1]), .bank1(wrAddr1[ADDR_W-1]),
    .strobes(strobes), .conflictFlag(bankConflict)
  );

  wrf_datapath #(.DATA_W(DATA_W), .ENTRIES(ENTRIES)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .wrAddr0(wrAddr0), .wrData0(wrData0),
    .wrAddr1(wrAddr1), .wrData1(wrData1),
    .rdEn(rdEnV), .rdAddr(rdAddrV), .rdData(rdDataV)
  );

  // R3: an idle read port presents zero at the block edge
  assert_idle_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (!rdEn0 |-> rdData0 == '0) and (!rdEn2 |-> rdData2 == '0));
endmodule

// File: tb/wide_regfile_tb.sv
module wide_regfile_tb;
  localparam int DW = 128;
  localparam int AW = 5;
  localparam int NV = 12;
  // vector: {we0, wa0, we1, wa1, ra}
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 5'h03, 1'b1, 5'h17, 5'h03},
    {1'b1, 5'h12, 1'b0, 5'h00, 5'h03},
    {1'b0, 5'h00, 1'b1, 5'h05, 5'h12},
    {1'b1, 5'h09, 1'b1, 5'h0A, 5'h09},
    {1'b1, 5'h14, 1'b1, 5'h14, 5'h17},
    {1'b1, 5'h09, 1'b1, 5'h19, 5'h09},
    {1'b1, 5'h1F, 1'b1, 5'h00, 5'h1F},
    {1'b0, 5'h1F, 1'b0, 5'h00, 5'h1F},
    {1'b1, 5'h00, 1'b1, 5'h10, 5'h00},
    {1'b1, 5'h03, 1'b1, 5'h13, 5'h13},
    {1'b0, 5'h01, 1'b1, 5'h11, 5'h01},
    {1'b0, 5'h00, 1'b0, 5'h00, 5'h11}
  };

  logic clk = 0, rst = 1;
  logic rdEn0 = 0, rdEn1 = 0, rdEn2 = 0;
  logic [AW-1:0] rdAddr0 = 0, rdAddr1 = 0, rdAddr2 = 0;
  logic [DW-1:0] rdData0, rdData1, rdData2;
  logic wrEn0 = 0, wrEn1 = 0;
  logic [AW-1:0] wrAddr0 = 0, wrAddr1 = 0;
  logic [DW-1:0] wrData0 = 0, wrData1 = 0;
  logic bankConflict;

  logic [DW-1:0] model [32];
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wide_regfile u_dut (.*);

  function automatic logic [DW-1:0] pat(int v, int port);
    logic [31:0] w;
    w = 32'hC300_0000 ^ (32'(v + 1) * 32'h0101_0101) ^ (port != 0 ? 32'hF0F0_0000 : 32'h0000_0F0F);
    return {w, ~w, w ^ 32'h5A5A_5A5A, 32'(v * 7 + port + 1)};
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkAllZero(string req);
    for (int a = 0; a < 32; a += 3) begin
      @(negedge clk);
      rdEn0 = 1; rdEn1 = 1; rdEn2 = 1;
      rdAddr0 = AW'(a); rdAddr1 = AW'((a + 1) % 32); rdAddr2 = AW'((a + 2) % 32);
      #1;
      check(req, rdData0, '0);
      check(req, rdData1, '0);
      check(req, rdData2, '0);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
    // R8: reset state
    check("R8 flag", {127'b0, bankConflict}, '0);
    checkAllZero("R8 reset contents");

    // table walk: R1 R2 R4 R5 R6 R7 R9
    for (int v = 0; v < NV; v++) begin
      logic we0, we1, expConf;
      logic [AW-1:0] wa0, wa1, ra;
      {we0, wa0, we1, wa1, ra} = VEC[v];
      expConf = we0 && we1 && (wa0[4] == wa1[4]);
      @(negedge clk);
      wrEn0 = we0; wrAddr0 = wa0; wrData0 = pat(v, 0);
      wrEn1 = we1; wrAddr1 = wa1; wrData1 = pat(v, 1);
      rdEn0 = 1; rdAddr0 = ra;
      rdEn1 = 1; rdAddr1 = wa1;
      rdEn2 = 0; rdAddr2 = wa0;
      #1;
      check("R5 old value port0", rdData0, model[ra]);
      check("R2 port1", rdData1, model[wa1]);
      check("R3 idle port2", rdData2, '0);
      @(posedge clk);
      if (!expConf) begin
        if (we0) model[wa0] = pat(v, 0);
        if (we1) model[wa1] = pat(v, 1);
      end
      #1;
      check("R6 flag", {127'b0, bankConflict}, {127'b0, expConf});
      check("R4 R7 R9 post-edge port0", rdData0, model[ra]);
      check("R1 R6 post-edge port1", rdData1, model[wa1]);
    end

    // R6: flag lasts one cycle
    @(negedge clk);
    wrEn0 = 1; wrAddr0 = 5'h04; wrEn1 = 1; wrAddr1 = 5'h08;
    @(negedge clk);
    wrEn0 = 0; wrEn1 = 0;
    check("R6 flag set", {127'b0, bankConflict}, 128'd1);
    @(negedge clk);
    check("R6 flag cleared", {127'b0, bankConflict}, '0);
    rdEn0 = 1; rdAddr0 = 5'h04; rdEn1 = 1; rdAddr1 = 5'h08; #1;
    check("R6 dropped write0", rdData0, model[4]);
    check("R6 dropped write1", rdData1, model[8]);

    // R2: three distinct ports together
    @(negedge clk);
    rdEn0 = 1; rdAddr0 = 5'h1F; rdEn1 = 1; rdAddr1 = 5'h09; rdEn2 = 1; rdAddr2 = 5'h19; #1;
    check("R2 port0", rdData0, model[31]);
    check("R2 port1", rdData1, model[9]);
    check("R2 port2", rdData2, model[25]);

    // R8: reset after data written
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R8 flag after reset", {127'b0, bankConflict}, '0);
    checkAllZero("R8 cleared after use");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule